// File: doc/BRIEF.md
# ALU operation selector

This combinational stage sits in front of the ALU of a single-cycle datapath. It takes the 3-bit operation class from the main decoder, the 6-bit function field of the instruction and an operand-source select. From these it produces the 3-bit code that steers the ALU, the second ALU operand and an invalid flag. The invalid flag tells the sequencer to halt.

Class values 000 to 110 name an ALU operation directly. Class 111 marks a register-register instruction, and the operation then comes from the function field. An unsupported function code stops execution; it never falls back to a default operation. The second operand is either register data or the immediate sign-extended to the data width.

Top module: `alu_op_select`

## Requirements
- R1: For alu_op_i 000 to 110, alu_ctrl_o equals alu_op_i and invalid_o is 0, whatever funct_i holds. The codes mean 000 add, 001 subtract, 010 signed less-than, 011 unsigned less-than, 100 AND, 101 OR, 110 immediate shifted left by 16, 111 NOR.
- R2: With alu_op_i = 111 and funct_i = 0x20, alu_ctrl_o is 000 (add) and invalid_o is 0.
- R3: With alu_op_i = 111, funct_i values map as follows, each with invalid_o = 0: 0x22 gives 001, 0x24 gives 100, 0x25 gives 101, 0x27 gives 111, 0x2A gives 010 and 0x2B gives 011.
- R4: With alu_op_i = 111 and any funct_i other than those in R2 and R3, invalid_o is 1 and alu_ctrl_o is 000.
- R5: With alu_src_i = 0, operand_b_o equals reg_data_i.
- R6: With alu_src_i = 1, operand_b_o[15:0] equals imm_i, and every bit of operand_b_o[31:16] equals imm_i[15].
- R7: invalid_o is 1 only when alu_op_i = 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op_i | input | 3 | Operation class from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| alu_src_i | input | 1 | Second operand select: 0 register, 1 immediate |
| reg_data_i | input | 32 | Second register read value |
| imm_i | input | 16 | Immediate field of the instruction |
| operand_b_o | output | 32 | Second ALU operand |
| alu_ctrl_o | output | 3 | ALU operation code |
| invalid_o | output | 1 | Unsupported combination, halt |

## Verification
The checker assumes that all inputs carry known values, and it skips evaluation while any of them is X or Z. The bench drives every input from time zero, so no check runs on undriven state. It then covers all 512 class and function pairs, together with register and immediate operands on both sides of the sign bit.

// File: rtl/alu_sel_pkg.sv
package alu_sel_pkg;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned FUNCT_W = 6;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 3'b000,
    ALU_SUB  = 3'b001,
    ALU_SLT  = 3'b010,
    ALU_SLTU = 3'b011,
    ALU_AND  = 3'b100,
    ALU_OR   = 3'b101,
    ALU_LUI  = 3'b110,
    ALU_NOR  = 3'b111
  } alu_ctrl_e;

  localparam logic [OP_W-1:0] CLASS_RTYPE = 3'b111;

  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FUNCT_W-1:0] FN_SLTU = 6'h2B;
endpackage

// File: rtl/sign_ext.sv
module sign_ext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end else begin : g_trunc
      assign val_o = val_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              alu_src_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] operand_b_o
);
  logic [DATA_W-1:0] imm_ext;

  sign_ext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_sext (
    .val_i (imm_i),
    .val_o (imm_ext)
  );

  assign operand_b_o = alu_src_i ? imm_ext : reg_data_i;
endmodule

// File: rtl/funct_decode.sv
module funct_decode
  import alu_sel_pkg::*;
(
  input  logic [OP_W-1:0]    alu_op_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output logic [OP_W-1:0]    alu_ctrl_o,
  output logic               invalid_o
);
  logic [OP_W-1:0] fn_ctrl;
  logic            fn_bad;

  always_comb begin
    fn_bad  = 1'b0;
    fn_ctrl = ALU_ADD;
    unique case (funct_i)
      FN_ADD:  fn_ctrl = ALU_ADD;
      FN_SUB:  fn_ctrl = ALU_SUB;
      FN_AND:  fn_ctrl = ALU_AND;
      FN_OR:   fn_ctrl = ALU_OR;
      FN_NOR:  fn_ctrl = ALU_NOR;
      FN_SLT:  fn_ctrl = ALU_SLT;
      FN_SLTU: fn_ctrl = ALU_SLTU;
      default: fn_bad  = 1'b1;
    endcase
  end

  always_comb begin
    if (alu_op_i != CLASS_RTYPE) begin
      alu_ctrl_o = alu_op_i;
      invalid_o  = 1'b0;
    end else begin
      // halt forces a harmless add code
      alu_ctrl_o = fn_bad ? ALU_ADD : fn_ctrl;
      invalid_o  = fn_bad;
    end
  end
endmodule

// File: rtl/alu_op_select.sv
module alu_op_select
  import alu_sel_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [OP_W-1:0]    alu_op_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic               alu_src_i,
  input  logic [DATA_W-1:0]  reg_data_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic [DATA_W-1:0]  operand_b_o,
  output logic [OP_W-1:0]    alu_ctrl_o,
  output logic               invalid_o
);
  funct_decode u_dec (
    .alu_op_i   (alu_op_i),
    .funct_i    (funct_i),
    .alu_ctrl_o (alu_ctrl_o),
    .invalid_o  (invalid_o)
  );

  operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mux (
    .alu_src_i   (alu_src_i),
    .reg_data_i  (reg_data_i),
    .imm_i       (imm_i),
    .operand_b_o (operand_b_o)
  );
endmodule

// File: rtl/alu_op_select_chk.sv
module alu_op_select_chk
  import alu_sel_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input logic [OP_W-1:0]    alu_op_i,
  input logic [FUNCT_W-1:0] funct_i,
  input logic               alu_src_i,
  input logic [DATA_W-1:0]  reg_data_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic [DATA_W-1:0]  operand_b_o,
  input logic [OP_W-1:0]    alu_ctrl_o,
  input logic               invalid_o
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic known;
  assign known = !$isunknown({alu_op_i, funct_i, alu_src_i, reg_data_i, imm_i});

  always_comb begin
    if (known) begin
      a_r1_direct_pass: assert (alu_op_i == CLASS_RTYPE || (alu_ctrl_o == alu_op_i && !invalid_o));
      a_r4_halt_code_zero: assert (!invalid_o || alu_ctrl_o == ALU_ADD);
      a_r7_halt_rtype_only: assert (!invalid_o || alu_op_i == CLASS_RTYPE);
      a_r2_add_ok: assert (!(alu_op_i == CLASS_RTYPE && funct_i == FN_ADD) || (!invalid_o && alu_ctrl_o == ALU_ADD));
      a_r5_reg_operand: assert (alu_src_i || operand_b_o == reg_data_i);
      a_r6_imm_low: assert (!alu_src_i || operand_b_o[IMM_W-1:0] == imm_i);
      a_r6_imm_sign: assert (!alu_src_i ||
        $countones(operand_b_o[DATA_W-1:IMM_W]) == (imm_i[IMM_W-1] ? PAD_W : 0));
    end
  end
endmodule

bind alu_op_select alu_op_select_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .alu_op_i    (alu_op_i),
  .funct_i     (funct_i),
  .alu_src_i   (alu_src_i),
  .reg_data_i  (reg_data_i),
  .imm_i       (imm_i),
  .operand_b_o (operand_b_o),
  .alu_ctrl_o  (alu_ctrl_o),
  .invalid_o   (invalid_o)
);

// File: tb/tb_alu_op_select.sv
module tb_alu_op_select;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  alu_op;
  logic [5:0]  funct;
  logic        alu_src;
  logic [31:0] reg_data;
  logic [15:0] imm;
  logic [31:0] operand_b;
  logic [2:0]  alu_ctrl;
  logic        invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_op_select dut (
    .alu_op_i    (alu_op),
    .funct_i     (funct),
    .alu_src_i   (alu_src),
    .reg_data_i  (reg_data),
    .imm_i       (imm),
    .operand_b_o (operand_b),
    .alu_ctrl_o  (alu_ctrl),
    .invalid_o   (invalid)
  );

  // {op[12:10], funct[9:4], ctrl[3:1], inv[0]}
  localparam logic [12:0] VEC [16] = '{
    {3'b111, 6'h20, 3'b000, 1'b0},
    {3'b111, 6'h22, 3'b001, 1'b0},
    {3'b111, 6'h24, 3'b100, 1'b0},
    {3'b111, 6'h25, 3'b101, 1'b0},
    {3'b111, 6'h27, 3'b111, 1'b0},
    {3'b111, 6'h2A, 3'b010, 1'b0},
    {3'b111, 6'h2B, 3'b011, 1'b0},
    {3'b111, 6'h00, 3'b000, 1'b1},
    {3'b111, 6'h21, 3'b000, 1'b1},
    {3'b111, 6'h3F, 3'b000, 1'b1},
    {3'b000, 6'h3F, 3'b000, 1'b0},
    {3'b001, 6'h00, 3'b001, 1'b0},
    {3'b010, 6'h22, 3'b010, 1'b0},
    {3'b011, 6'h2B, 3'b011, 1'b0},
    {3'b100, 6'h11, 3'b100, 1'b0},
    {3'b110, 6'h27, 3'b110, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic [5:0] fn);
    if (op != 3'b111) return "R1";
    if (fn == 6'h20) return "R2";
    if (fn inside {6'h22, 6'h24, 6'h25, 6'h27, 6'h2A, 6'h2B}) return "R3";
    return "R4";
  endfunction

  function automatic logic [3:0] model(input logic [2:0] op, input logic [5:0] fn);
    if (op != 3'b111) return {op, 1'b0};
    case (fn)
      6'h20: return 4'b0000;
      6'h22: return 4'b0010;
      6'h24: return 4'b1000;
      6'h25: return 4'b1010;
      6'h27: return 4'b1110;
      6'h2A: return 4'b0100;
      6'h2B: return 4'b0110;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [5:0] fn, input logic src,
                       input logic [31:0] rd, input logic [15:0] im);
    @(negedge clk);
    alu_op = op; funct = fn; alu_src = src; reg_data = rd; imm = im;
    #2;
  endtask

  initial begin
    alu_op = '0; funct = '0; alu_src = 1'b0; reg_data = '0; imm = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // idle state: class add, register operand zero
    chk("R1 idle ctrl", {29'd0, alu_ctrl}, 32'd0);
    chk("R1 idle inv", {31'd0, invalid}, 32'd0);
    chk("R5 idle opb", operand_b, 32'd0);

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][12:10], VEC[i][9:4], 1'b0, 32'h1234_5678, 16'h0);
      chk({req_of(VEC[i][12:10], VEC[i][9:4]), " vec ctrl"}, {29'd0, alu_ctrl}, {29'd0, VEC[i][3:1]});
      chk({req_of(VEC[i][12:10], VEC[i][9:4]), " vec inv"}, {31'd0, invalid}, {31'd0, VEC[i][0]});
    end

    // full sweep; R7 checked via inv expectation on every class
    for (int o = 0; o < 8; o++) begin
      for (int f = 0; f < 64; f++) begin
        logic [3:0] e;
        e = model(3'(o), 6'(f));
        apply(3'(o), 6'(f), 1'b0, 32'h0, 16'h0);
        if ({alu_ctrl, invalid} !== e) begin
          checks++; errors++;
          $display("FAIL %s R7 sweep op %0d fn %h actual %b expected %b",
                   req_of(3'(o), 6'(f)), o, f, {alu_ctrl, invalid}, e);
        end else checks++;
      end
    end

    apply(3'b000, 6'h20, 1'b0, 32'hDEAD_BEEF, 16'hFFFF);
    chk("R5 reg select", operand_b, 32'hDEAD_BEEF);
    apply(3'b000, 6'h20, 1'b0, 32'h8000_0001, 16'h7FFF);
    chk("R5 reg select b", operand_b, 32'h8000_0001);
    apply(3'b000, 6'h20, 1'b1, 32'hDEAD_BEEF, 16'h7FFF);
    chk("R6 positive imm", operand_b, 32'h0000_7FFF);
    apply(3'b110, 6'h20, 1'b1, 32'h0, 16'h8000);
    chk("R6 negative imm", operand_b, 32'hFFFF_8000);
    apply(3'b001, 6'h20, 1'b1, 32'hFFFF_FFFF, 16'h0000);
    chk("R6 zero imm", operand_b, 32'h0000_0000);
    apply(3'b111, 6'h2B, 1'b1, 32'h0, 16'hFFFF);
    chk("R6 all ones imm", operand_b, 32'hFFFF_FFFF);
    chk("R3 sltu with imm", {29'd0, alu_ctrl}, 32'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule